// File: doc/BRIEF.md
# Decrementer Timer Interrupt Unit

This block keeps a 64-bit count that moves down by one on each qualified tick. When a tick finds the count already at zero, the block raises a request that stays up until the core accepts it. While the count is nonzero, every tick takes exactly one off it and the request line does not move. Software can load the count at any time through a write port.

The request and accept pins work as a valid/ready pair. `irq_req` is the valid, and it is held until it is taken. `irq_take` is the ready, and the core may hold it low for as long as it likes. A transfer happens only in a cycle where both are high, so holding `irq_take` low is the only form of back-pressure.

In the transfer cycle the block does the following:
- It shows the fixed vector on the redirect outputs, combinationally.
- At the same clock edge, it stores the current instruction address in save/restore register 0.
- At that edge it also stores a masked copy of the machine state register in save/restore register 1, and clears selected bits of the machine state register.
- It reloads the count with all ones and drops the request.

A separate write port loads the machine state register.

Top module: `dec_intr_unit`

## Requirements
- R1: On a tick with no transfer and no count write, a nonzero count drops by exactly one and `irq_req` keeps its value.
- R2: In a cycle with no tick, no count write and no transfer, the count keeps its value.
- R3: A tick that finds the count at zero sets `irq_req` from the next cycle on. After a count of N is written, `irq_req` therefore rises after exactly N+1 ticks.
- R4: `irq_req` stays high until a transfer. `irq_take` while `irq_req` is low has no effect: no redirect, and the count, MSR, SRR0 and SRR1 do not change.
- R5: On a transfer, SRR0 is loaded with `cur_ia`.
- R6: On a transfer, SRR1 is loaded with the old MSR ANDed with 64'hFFFF_FFFF_78FC_0FFF.
- R7: On a transfer, the MSR becomes its old value ANDed with 64'hFFFF_FFFF_FFFF_76CD. A transfer has priority over an MSR write in the same cycle.
- R8: `redir_valid` is high in exactly the cycles of a transfer, combinationally. While it is high, `redir_addr` is 64'h900.
- R9: After a transfer the count is all ones and `irq_req` is low. A transfer has priority over a count write and over a tick in the same cycle.
- R10: A count write takes priority over a tick in the same cycle, so that tick is not evaluated. A count write leaves `irq_req` as it was.
- R11: After reset the count is all ones, `irq_req` is low, and MSR, SRR0 and SRR1 are zero.
- R12: An MSR write with no transfer loads `msr_wr_data` into the MSR at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Qualified count tick |
| dec_wr_en | input | 1 | Count write strobe |
| dec_wr_data | input | 64 | Count write value |
| msr_wr_en | input | 1 | MSR write strobe |
| msr_wr_data | input | 64 | MSR write value |
| cur_ia | input | 64 | Address of the current instruction |
| irq_take | input | 1 | Core accepts the request (ready) |
| irq_req | output | 1 | Interrupt request, held until taken (valid) |
| redir_valid | output | 1 | Program counter redirect strobe |
| redir_addr | output | 64 | Redirect target |
| dec_value | output | 64 | Current count |
| msr_value | output | 64 | Machine state register |
| srr0_value | output | 64 | Save/restore register 0 |
| srr1_value | output | 64 | Save/restore register 1 |

## Verification
A wrong count appears on `dec_value` one cycle after the faulty update. It also shifts the rise of `irq_req` by a whole tick, so a count that is off by one is caught against the N+1 tick rule. A pending flag that is lost or set too early appears on `irq_req` at the next edge. The redirect follows from that flag in the same cycle. A wrong mask, or a capture made at the wrong priority, corrupts `msr_value`, `srr0_value` or `srr1_value` one edge after the transfer, where it is compared bit for bit.

// File: rtl/dec_pkg.sv
`timescale 1ns/1ps
package dec_pkg;
  parameter int XLEN = 64;
  typedef logic [XLEN-1:0] word_t;
  // bits of the MSR copied into SRR1 on entry
  localparam word_t SRR1_KEEP = 64'hFFFF_FFFF_78FC_0FFF;
  // bits of the MSR that survive entry
  localparam word_t MSR_KEEP  = 64'hFFFF_FFFF_FFFF_76CD;
  localparam word_t VECTOR    = 64'h0000_0000_0000_0900;
  localparam word_t RELOAD    = '1;
endpackage

// File: rtl/dec_counter.sv
`timescale 1ns/1ps
module dec_counter
  import dec_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  wr_en,
  input  word_t wr_data,
  input  logic  fire,
  output word_t cnt_q,
  output logic  pend_q
);
  logic at_zero;
  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= RELOAD;
      pend_q <= 1'b0;
    end else if (fire) begin
      cnt_q  <= RELOAD;
      pend_q <= 1'b0;
    end else if (wr_en) begin
      cnt_q  <= wr_data;
    end else if (tick) begin
      if (at_zero) pend_q <= 1'b1;
      else         cnt_q  <= cnt_q - 1'b1;
    end
  end

  assert_step_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wr_en && !fire && !at_zero |=> cnt_q == $past(cnt_q) - 1'b1 && pend_q == $past(pend_q));
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !wr_en && !fire |=> $stable(cnt_q));
  assert_zero_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wr_en && !fire && at_zero |=> pend_q);
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !fire |=> pend_q);
  assert_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> cnt_q == RELOAD && !pend_q);
  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !fire |=> cnt_q == $past(wr_data) && pend_q == $past(pend_q));
endmodule

// File: rtl/dec_entry.sv
`timescale 1ns/1ps
module dec_entry
  import dec_pkg::*;
#(
  parameter word_t MSR_RESET = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fire,
  input  word_t cur_ia,
  input  logic  msr_wr_en,
  input  word_t msr_wr_data,
  output word_t msr_q,
  output word_t srr0_q,
  output word_t srr1_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msr_q  <= MSR_RESET;
      srr0_q <= '0;
      srr1_q <= '0;
    end else if (fire) begin
      srr0_q <= cur_ia;
      srr1_q <= msr_q & SRR1_KEEP;
      msr_q  <= msr_q & MSR_KEEP;
    end else if (msr_wr_en) begin
      msr_q  <= msr_wr_data;
    end
  end

  assert_srr0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> srr0_q == $past(cur_ia));
  assert_srr1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> srr1_q == ($past(msr_q) & SRR1_KEEP));
  assert_msr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> msr_q == ($past(msr_q) & MSR_KEEP));
  assert_msr_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
    msr_wr_en && !fire |=> msr_q == $past(msr_wr_data));
  assert_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fire && !msr_wr_en |=> $stable(msr_q) && $stable(srr0_q) && $stable(srr1_q));
endmodule

// File: rtl/dec_intr_unit.sv
`timescale 1ns/1ps
module dec_intr_unit
  import dec_pkg::*;
#(
  parameter word_t MSR_RESET = '0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        dec_wr_en,
  input  logic [63:0] dec_wr_data,
  input  logic        msr_wr_en,
  input  logic [63:0] msr_wr_data,
  input  logic [63:0] cur_ia,
  input  logic        irq_take,
  output logic        irq_req,
  output logic        redir_valid,
  output logic [63:0] redir_addr,
  output logic [63:0] dec_value,
  output logic [63:0] msr_value,
  output logic [63:0] srr0_value,
  output logic [63:0] srr1_value
);
  logic pend;
  logic fire;

  // a transfer needs both sides of the handshake
  assign fire        = irq_take & pend;
  assign irq_req     = pend;
  assign redir_valid = fire;
  assign redir_addr  = VECTOR;

  dec_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_en),
    .wr_en   (dec_wr_en),
    .wr_data (dec_wr_data),
    .fire    (fire),
    .cnt_q   (dec_value),
    .pend_q  (pend)
  );

  dec_entry #(.MSR_RESET(MSR_RESET)) u_ent (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire),
    .cur_ia      (cur_ia),
    .msr_wr_en   (msr_wr_en),
    .msr_wr_data (msr_wr_data),
    .msr_q       (msr_value),
    .srr0_q      (srr0_value),
    .srr1_q      (srr1_value)
  );

  assert_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> !irq_req && dec_value == RELOAD);
endmodule

// File: tb/test_dec_intr_unit.sv
`timescale 1ns/1ps
module test_dec_intr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, dec_wr_en = 1'b0, msr_wr_en = 1'b0, irq_take = 1'b0;
  logic [63:0] dec_wr_data = '0, msr_wr_data = '0, cur_ia = '0;
  logic        irq_req, redir_valid;
  logic [63:0] redir_addr, dec_value, msr_value, srr0_value, srr1_value;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [63:0] m_dec, m_msr, m_srr0, m_srr1;
  logic        m_pend;

  always #2 clk = ~clk;

  dec_intr_unit i_dec_intr_unit (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .dec_wr_en(dec_wr_en),
    .dec_wr_data(dec_wr_data), .msr_wr_en(msr_wr_en), .msr_wr_data(msr_wr_data),
    .cur_ia(cur_ia), .irq_take(irq_take), .irq_req(irq_req),
    .redir_valid(redir_valid), .redir_addr(redir_addr), .dec_value(dec_value),
    .msr_value(msr_value), .srr0_value(srr0_value), .srr1_value(srr1_value)
  );

  function automatic logic [63:0] srr1_of(logic [63:0] m);
    return m & 64'hFFFF_FFFF_78FC_0FFF;
  endfunction
  function automatic logic [63:0] msr_after(logic [63:0] m);
    return m & 64'hFFFF_FFFF_FFFF_76CD;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: inputs driven after negedge, redirect checked before the edge,
  // registered outputs checked 1 ns after the edge
  task automatic step(bit t, bit w, logic [63:0] wd, bit k, logic [63:0] ia,
                      bit mw, logic [63:0] mwd);
    bit f;
    tick_en = t; dec_wr_en = w; dec_wr_data = wd; irq_take = k;
    cur_ia = ia; msr_wr_en = mw; msr_wr_data = mwd;
    f = k && m_pend;
    #1;
    chk(redir_valid == f, "R8 R4 redir_valid", {63'd0, redir_valid}, {63'd0, f});
    if (f) chk(redir_addr == 64'h900, "R8 redir_addr", redir_addr, 64'h900);
    if (f) begin
      m_srr0 = ia; m_srr1 = srr1_of(m_msr); m_msr = msr_after(m_msr);
      m_dec = '1; m_pend = 1'b0;
    end else begin
      if (mw) m_msr = mwd;
      if (w) m_dec = wd;
      else if (t) begin
        if (m_dec == 0) m_pend = 1'b1;
        else m_dec = m_dec - 1;
      end
    end
    @(posedge clk); #1;
    chk(dec_value == m_dec, "R1 R2 R9 R10 dec_value", dec_value, m_dec);
    chk(irq_req == m_pend, "R3 R4 R9 R10 irq_req", {63'd0, irq_req}, {63'd0, m_pend});
    chk(msr_value == m_msr, "R7 R12 msr_value", msr_value, m_msr);
    chk(srr0_value == m_srr0, "R5 srr0_value", srr0_value, m_srr0);
    chk(srr1_value == m_srr1, "R6 srr1_value", srr1_value, m_srr1);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int nt;
    void'($urandom(32'd1234));
    m_dec = '1; m_pend = 1'b0; m_msr = '0; m_srr0 = '0; m_srr1 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    // R11 reset state
    chk(dec_value == '1, "R11 reset dec", dec_value, '1);
    chk(!irq_req, "R11 reset req", {63'd0, irq_req}, 64'd0);
    chk(msr_value == 0 && srr0_value == 0 && srr1_value == 0, "R11 reset msr/srr",
        msr_value | srr0_value | srr1_value, 64'd0);
    @(negedge clk);
    // R10 preload, R3 exactly count+1 ticks
    step(0, 1, 64'd5, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    nt = 0;
    for (int i = 0; i < 10 && !irq_req; i++) begin
      step(1, 0, 0, 0, 0, 0, 0);
      nt++;
    end
    chk(nt == 6, "R3 ticks to request", 64'(nt), 64'd6);
    // R4 request held while not taken, ticks at zero keep it
    step(1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    // R10 write while pending keeps request
    step(1, 1, 64'd3, 0, 0, 0, 0);
    // R5 R6 R7 R8 R9 transfer beats MSR write, count write and tick
    step(1, 1, 64'd9, 1, 64'h0000_1234_5678_9ABC, 1, 64'h0);
    chk(srr1_value == 64'hFFFF_FFFF_78FC_0FFF, "R6 srr1 mask", srr1_value, 64'hFFFF_FFFF_78FC_0FFF);
    chk(msr_value == 64'hFFFF_FFFF_FFFF_76CD, "R7 msr mask", msr_value, 64'hFFFF_FFFF_FFFF_76CD);
    // R4 take without request has no effect
    step(0, 0, 0, 1, 64'hDEAD, 0, 0);
    // R12 MSR write
    step(0, 0, 0, 0, 0, 1, 64'h0123_4567_89AB_CDEF);
    // R2 idle hold
    step(0, 0, 0, 0, 0, 0, 0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 2) == 0, ($urandom % 16) == 0, 64'($urandom % 6),
           ($urandom % 4) == 0, {$urandom, $urandom},
           ($urandom % 16) == 0, {$urandom, $urandom});
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule